// File: doc/BRIEF.md
# Trap and Interrupt Sequencer

This unit decides where a multicycle processor fetches next when control leaves the normal instruction stream. It watches the synchronous fault requests raised by the datapath (undefined opcode, arithmetic overflow). It also watches a one-bit pending-interrupt flag that an outside device sets, and the completion of a return-from-trap instruction. From these it produces a program-counter source select and the matching target address. In the same decision it updates a saved-return-address register and a trap-cause register.

The controller pulses `instr_end_i` in the last cycle of every instruction. The pending interrupt is examined only in that cycle. It is serviced only when no synchronous fault is raised in that cycle, so faults always win. Servicing it saves the address of the next instruction, writes the interrupt cause code, clears the flag and sends the PC to the interrupt vector. A return-from-trap instruction, which is flagged by `rfe_i` in its final cycle, selects the saved return address as the next PC. The PC select and target are combinational, so they act in the cycle of the request. The saved address, the cause and the flag change on the following clock edge.

Top module: `exc_seq_unit`

## Requirements
- R1: After synchronous reset with all request inputs low, `irq_pending_o` is 0, `epc_o` is 0, `cause_o` is 5'h1F (no cause), and `pc_sel_o` is 0 (sequential) with `pc_target_o` equal to `pc_next_seq_i`.
- R2: A cycle with `irq_set_i` high makes `irq_pending_o` 1 from the next cycle on. The flag stays 1 until an interrupt is taken.
- R3: Outside an instruction boundary (`instr_end_i` low), a pending flag is ignored. With no fault raised, `pc_sel_o` is 0, `pc_target_o` equals `pc_next_seq_i`, and the flag, `epc_o` and `cause_o` keep their values.
- R4: When `exc_undef_i` or `exc_ovf_i` is high, `pc_sel_o` is 1 and `pc_target_o` is 0x80000180 in that cycle, whatever the other inputs are. On the next edge `epc_o` takes `pc_cur_i` and `cause_o` takes 10 (undefined, which takes priority) or 12 (overflow). The flag is not cleared.
- R5: With `instr_end_i` high, the flag set and no fault, the interrupt is taken. `pc_sel_o` is 1 and `pc_target_o` is 0x80000200 in that cycle. On the next edge `epc_o` takes `pc_next_seq_i`, `cause_o` takes 0 and the flag clears.
- R6: If `irq_set_i` is high in the cycle an interrupt is taken, the flag is 1 afterwards (the set wins over the clear).
- R7: With `instr_end_i` and `rfe_i` high, no fault and no pending flag, `pc_sel_o` is 2 and `pc_target_o` equals `epc_o`. `epc_o` and `cause_o` are unchanged.
- R8: If an interrupt is taken at the boundary of a return-from-trap (`rfe_i` high), `epc_o` keeps its value, so the return address is preserved. `cause_o` becomes 0 and the target is 0x80000200.
- R9: `pc_sel_o` only ever takes the values 0 (sequential), 1 (vector) or 2 (saved address), never 3.
- R10: At a boundary with no flag, no fault and no return, `pc_sel_o` is 0, `pc_target_o` equals `pc_next_seq_i`, and `epc_o`/`cause_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set_i | input | 1 | Device request; sets the pending flag |
| instr_end_i | input | 1 | Last cycle of the current instruction |
| rfe_i | input | 1 | Current instruction is a return-from-trap |
| exc_undef_i | input | 1 | Undefined-instruction fault this cycle |
| exc_ovf_i | input | 1 | Arithmetic-overflow fault this cycle |
| pc_cur_i | input | 32 | Address of the instruction in progress |
| pc_next_seq_i | input | 32 | Next PC the datapath would use on its own |
| irq_pending_o | output | 1 | Pending-interrupt flag |
| epc_o | output | 32 | Saved return address |
| cause_o | output | 5 | Trap-cause code |
| pc_sel_o | output | 2 | Next-PC source: 0 sequential, 1 vector, 2 saved address |
| pc_target_o | output | 32 | Next-PC value for the selected source |

## Verification
The hardest situation to reach is an instruction boundary where a set request meets the clear of an interrupt being taken, possibly during a return-from-trap and with a fault competing. Each of these needs the flag already pending before the stimulus cycle. The bench therefore walks every combination of the six control conditions, including the prior flag state. Before each combination it runs a preparation step that either raises the flag or drains it through a taken interrupt. It then applies the combination and compares the select, target, flag, saved address and cause with an arithmetic model.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        PCSEL_SEQ = 2'd0,
        PCSEL_VEC = 2'd1,
        PCSEL_EPC = 2'd2
    } pc_sel_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IRQ   = 5'd0,
        CAUSE_UNDEF = 5'd10,
        CAUSE_OVF   = 5'd12,
        CAUSE_NONE  = 5'd31
    } cause_e;

    typedef enum logic [1:0] {
        EPC_HOLD = 2'd0,
        EPC_CUR  = 2'd1,
        EPC_NEXT = 2'd2
    } epc_src_e;

    typedef struct packed {
        pc_sel_e  sel;
        logic     vec_irq;
        logic     save;
        epc_src_e epc_src;
        cause_e   cause;
        logic     clr_irq;
    } decision_t;

    function automatic cause_e fault_code(input logic undef);
        return undef ? CAUSE_UNDEF : CAUSE_OVF;
    endfunction

endpackage

// File: rtl/exc_irq_flag.sv
module exc_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= set_i | (flag_q & ~clr_i);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  logic      irq_pending_i,
    input  logic      instr_end_i,
    input  logic      rfe_i,
    input  logic      exc_undef_i,
    input  logic      exc_ovf_i,
    output decision_t dec_o
);
    logic fault;
    logic take_irq;

    assign fault    = exc_undef_i | exc_ovf_i;
    assign take_irq = instr_end_i & irq_pending_i & ~fault;

    always_comb begin
        dec_o         = '0;
        dec_o.sel     = PCSEL_SEQ;
        dec_o.epc_src = EPC_HOLD;
        dec_o.cause   = CAUSE_NONE;
        if (fault) begin
            dec_o.sel     = PCSEL_VEC;
            dec_o.save    = 1'b1;
            dec_o.epc_src = EPC_CUR;
            dec_o.cause   = fault_code(exc_undef_i);
        end else if (take_irq) begin
            dec_o.sel     = PCSEL_VEC;
            dec_o.vec_irq = 1'b1;
            dec_o.save    = 1'b1;
            dec_o.epc_src = rfe_i ? EPC_HOLD : EPC_NEXT;
            dec_o.cause   = CAUSE_IRQ;
            dec_o.clr_irq = 1'b1;
        end else if (instr_end_i && rfe_i) begin
            dec_o.sel = PCSEL_EPC;
        end
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  decision_t       dec_i,
    input  logic [XLEN-1:0] pc_cur_i,
    input  logic [XLEN-1:0] pc_next_i,
    output logic [XLEN-1:0] epc_o,
    output cause_e          cause_o
);
    logic [XLEN-1:0] epc_q;
    cause_e          cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            cause_q <= CAUSE_NONE;
        end else if (dec_i.save) begin
            cause_q <= dec_i.cause;
            case (dec_i.epc_src)
                EPC_CUR:  epc_q <= pc_cur_i;
                EPC_NEXT: epc_q <= pc_next_i;
                default:  epc_q <= epc_q;
            endcase
        end
    end

    assign epc_o   = epc_q;
    assign cause_o = cause_q;
endmodule

// File: rtl/exc_pc_mux.sv
module exc_pc_mux
    import exc_seq_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] EXC_VECTOR = 32'h8000_0180,
    parameter logic [XLEN-1:0] IRQ_VECTOR = 32'h8000_0200
) (
    input  decision_t       dec_i,
    input  logic [XLEN-1:0] pc_next_i,
    input  logic [XLEN-1:0] epc_i,
    output logic [XLEN-1:0] target_o
);
    always_comb begin
        case (dec_i.sel)
            PCSEL_VEC: target_o = dec_i.vec_irq ? IRQ_VECTOR : EXC_VECTOR;
            PCSEL_EPC: target_o = epc_i;
            default:   target_o = pc_next_i;
        endcase
    end
endmodule

// File: rtl/exc_seq_unit.sv
module exc_seq_unit
    import exc_seq_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] EXC_VECTOR = 32'h8000_0180,
    parameter logic [XLEN-1:0] IRQ_VECTOR = 32'h8000_0200
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_set_i,
    input  logic               instr_end_i,
    input  logic               rfe_i,
    input  logic               exc_undef_i,
    input  logic               exc_ovf_i,
    input  logic [XLEN-1:0]    pc_cur_i,
    input  logic [XLEN-1:0]    pc_next_seq_i,
    output logic               irq_pending_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [1:0]         pc_sel_o,
    output logic [XLEN-1:0]    pc_target_o
);
    decision_t dec;
    cause_e    cause_q;
    logic      flag;

    exc_irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (irq_set_i),
        .clr_i  (dec.clr_irq),
        .flag_o (flag)
    );

    exc_arbiter u_arb (
        .irq_pending_i (flag),
        .instr_end_i   (instr_end_i),
        .rfe_i         (rfe_i),
        .exc_undef_i   (exc_undef_i),
        .exc_ovf_i     (exc_ovf_i),
        .dec_o         (dec)
    );

    exc_state_regs #(.XLEN(XLEN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .dec_i     (dec),
        .pc_cur_i  (pc_cur_i),
        .pc_next_i (pc_next_seq_i),
        .epc_o     (epc_o),
        .cause_o   (cause_q)
    );

    exc_pc_mux #(
        .XLEN       (XLEN),
        .EXC_VECTOR (EXC_VECTOR),
        .IRQ_VECTOR (IRQ_VECTOR)
    ) u_mux (
        .dec_i     (dec),
        .pc_next_i (pc_next_seq_i),
        .epc_i     (epc_o),
        .target_o  (pc_target_o)
    );

    assign irq_pending_o = flag;
    assign cause_o       = cause_q;
    assign pc_sel_o      = dec.sel;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] EXC_VECTOR = 32'h8000_0180,
    parameter logic [XLEN-1:0] IRQ_VECTOR = 32'h8000_0200
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_set_i,
    input logic            instr_end_i,
    input logic            rfe_i,
    input logic            exc_undef_i,
    input logic            exc_ovf_i,
    input logic [XLEN-1:0] pc_cur_i,
    input logic [XLEN-1:0] pc_next_seq_i,
    input logic            irq_pending_o,
    input logic [XLEN-1:0] epc_o,
    input logic [4:0]      cause_o,
    input logic [1:0]      pc_sel_o,
    input logic [XLEN-1:0] pc_target_o
);
    logic fault;
    assign fault = exc_undef_i | exc_ovf_i;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        irq_set_i |=> irq_pending_o);

    // R2
    flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pending_o && !instr_end_i) |=> irq_pending_o);

    // R4
    fault_vector_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (pc_sel_o == 2'd1 && pc_target_o == EXC_VECTOR));

    // R4
    fault_epc_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (epc_o == $past(pc_cur_i)));

    // R5
    irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_end_i && irq_pending_o && !fault) |-> (pc_target_o == IRQ_VECTOR));

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_end_i && irq_pending_o && !fault) |=> (cause_o == 5'd0));

    // R3
    mid_instr_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (!instr_end_i && !fault) |-> (pc_sel_o == 2'd0 && pc_target_o == pc_next_seq_i));

    // R7
    restore_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_end_i && rfe_i && !irq_pending_o && !fault) |-> (pc_sel_o == 2'd2 && pc_target_o == epc_o));

    // R8
    rfe_irq_keep_epc_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_end_i && rfe_i && irq_pending_o && !fault) |=> $stable(epc_o));

    // R9
    sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
        pc_sel_o != 2'd3);
endmodule

bind exc_seq_unit exc_seq_chk #(
    .XLEN       (XLEN),
    .EXC_VECTOR (EXC_VECTOR),
    .IRQ_VECTOR (IRQ_VECTOR)
) u_chk (.*);

// File: tb/exc_seq_unit_tb_top.sv
`timescale 1ns/1ps
module exc_seq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        irq_set, instr_end, rfe, exc_undef, exc_ovf;
    logic [31:0] pc_cur, pc_next;
    logic        irq_pending;
    logic [31:0] epc;
    logic [4:0]  cause;
    logic [1:0]  pc_sel;
    logic [31:0] pc_target;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic        m_flag;
    logic [31:0] m_epc;
    logic [4:0]  m_cause;

    always #2 clk = ~clk;

    exc_seq_unit dut_i (
        .clk           (clk),
        .rst           (rst),
        .irq_set_i     (irq_set),
        .instr_end_i   (instr_end),
        .rfe_i         (rfe),
        .exc_undef_i   (exc_undef),
        .exc_ovf_i     (exc_ovf),
        .pc_cur_i      (pc_cur),
        .pc_next_seq_i (pc_next),
        .irq_pending_o (irq_pending),
        .epc_o         (epc),
        .cause_o       (cause),
        .pc_sel_o      (pc_sel),
        .pc_target_o   (pc_target)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one instruction-control cycle against the arithmetic model
    task automatic step(input logic s, input logic e, input logic r,
                        input logic u, input logic o,
                        input logic [31:0] cur, input logic [31:0] nxt);
        logic        flt, take;
        logic [1:0]  x_sel;
        logic [31:0] x_tgt;
        string       tg, ftg;
        irq_set = s; instr_end = e; rfe = r; exc_undef = u; exc_ovf = o;
        pc_cur = cur; pc_next = nxt;
        flt  = u | o;
        take = !flt && e && m_flag;
        if (flt) begin
            x_sel = 2'd1; x_tgt = 32'h8000_0180; tg = "R4";
        end else if (take) begin
            x_sel = 2'd1; x_tgt = 32'h8000_0200; tg = r ? "R8" : "R5";
        end else if (e && r) begin
            x_sel = 2'd2; x_tgt = m_epc; tg = "R7";
        end else begin
            x_sel = 2'd0; x_tgt = nxt; tg = e ? "R10" : "R3";
        end
        #1;
        chk(tg, "pc_sel", {30'd0, pc_sel}, {30'd0, x_sel});
        chk(tg, "pc_target", pc_target, x_tgt);
        chk("R9", "sel_legal", {31'd0, pc_sel == 2'd3}, 32'd0);
        if (flt) begin
            m_epc   = cur;
            m_cause = u ? 5'd10 : 5'd12;
        end else if (take) begin
            if (!r) m_epc = nxt;
            m_cause = 5'd0;
        end
        ftg    = (take && s) ? "R6" : (take ? "R5" : "R2");
        m_flag = s | (m_flag & ~take);
        @(posedge clk); #1;
        chk(ftg, "flag", {31'd0, irq_pending}, {31'd0, m_flag});
        chk(tg, "epc", epc, m_epc);
        chk(tg, "cause", {27'd0, cause}, {27'd0, m_cause});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_set = 0; instr_end = 0; rfe = 0; exc_undef = 0; exc_ovf = 0;
        pc_cur = 32'h0040_0000; pc_next = 32'h0040_0004;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "flag", {31'd0, irq_pending}, 32'd0);
        chk("R1", "epc", epc, 32'd0);
        chk("R1", "cause", {27'd0, cause}, 32'h1F);
        chk("R1", "pc_sel", {30'd0, pc_sel}, 32'd0);
        chk("R1", "pc_target", pc_target, 32'h0040_0004);
        m_flag = 1'b0; m_epc = 32'd0; m_cause = 5'h1F;
        @(posedge clk); #1;

        for (int c = 0; c < 64; c++) begin
            logic [31:0] cur, nxt;
            cur = 32'h0040_0000 + 32'(c) * 8;
            nxt = c[0] ? cur + 32'h100 : cur + 32'd4;
            // preparation: reach the wanted prior flag state
            if (c[5] && !m_flag)
                step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, cur - 32'd64, cur - 32'd60);
            else if (!c[5] && m_flag)
                step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, cur - 32'd32, cur - 32'd28);
            step(c[4], c[3], c[2], c[1], c[0], cur, nxt);
        end

        // R3: long pending flag with no boundary stays pending
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h100, 32'h104);
        for (int k = 0; k < 5; k++)
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h200 + 32'(k) * 4, 32'h204 + 32'(k) * 4);
        // R8 then R7: return with pending irq keeps address, then return restores it
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h300, 32'h304);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h8000_0210, 32'h8000_0214);

        irq_set = 0; instr_end = 0; rfe = 0; exc_undef = 0; exc_ovf = 0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule